// File: doc/BRIEF.md
# Distributed Wired-OR Bus Arbitration Agent

This block resolves bus ownership among several devices without any central arbiter. Each contending device raises a shared start line and drives its unique ID onto a set of shared ID lines. The shared lines resolve as the bitwise OR of everything driven. Every agent compares the resolved pattern with its own ID, starting at the most significant bit. Where the lines show a 1 above a 0 in its own ID, the agent stops driving that bit and every bit below it. It drives those bits again once the higher conflict goes away. After a fixed settling window, the lines hold the largest contending ID. The agent whose ID equals that pattern reports a win, and every other contender reports a loss.

The top level instantiates N agents and joins them through a model of the shared lines built from OR reductions. A device asks to contend by pulsing its request while no contest is running. A request that arrives while a contest is in progress is dropped. A win or loss shows as a one-cycle pulse, after which the lines are released.

Top module: `dist_arb_cluster`

## Requirements
- R1: While rst_n is low, and on the first cycle after it, grant, lost, done, start_line and bus_lines are all zero, whatever req holds.
- R2: An agent whose req is high at a rising edge while start_line is low joins a contest. From the next cycle, start_line is high and bus_lines shows the bitwise OR of the IDs of all agents that joined on that edge.
- R3: Exactly one contender per contest receives a grant pulse: the one with the numerically largest ID. grant bit i belongs to agent i, and agent i's ID is id_flat[i*ID_W +: ID_W].
- R4: Every contender other than the winner receives a lost pulse, in the same cycle as the grant. No agent has grant and lost high together.
- R5: The result appears exactly SETTLE cycles after the joining edge and lasts one cycle, with done high. In that cycle start_line is low and bus_lines is zero. done is low in the cycle before and in the cycle after.
- R6: An agent that is not contending drives zero onto the lines and never raises grant or lost. With no requests, done and bus_lines stay zero.
- R7: A request raised while start_line is high is ignored. That agent neither joins the running contest nor receives a result from it.
- R8: An agent that withdrew its lower bits because of a higher-order conflict drives them again once that conflict clears. The lines therefore settle on the full winning ID even when the winner withdrew bits in the first round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | N | Per-agent contend request, sampled when start_line is low |
| id_flat | input | N*ID_W | Unique ID of each agent, agent i in bits [i*ID_W +: ID_W] |
| grant | output | N | One-cycle win pulse per agent |
| lost | output | N | One-cycle loss pulse per agent |
| done | output | 1 | High in the cycle that carries a contest result |
| bus_lines | output | ID_W | Resolved OR of all ID drives |
| start_line | output | 1 | Resolved OR of all start drives |

## Verification
Suppose an agent's withdrawal mask is wrong, or it fails to restore bits after a conflict clears. The settled lines then differ from the largest ID, so the wrong agent wins, or nobody wins. That shows on grant and lost in the result cycle, SETTLE cycles after the join. Suppose the settle counter or the state register is wrong. Then done fires in the wrong cycle, or stays high for more than one cycle, and the start line is held or released early. Both are visible at the edge of the window. A stale drive register leaves a nonzero pattern on bus_lines after the contest, which is visible in the result cycle itself.

// File: rtl/dist_arb_pkg.sv
// Shared types for the distributed wired-OR arbitration agents.
package dist_arb_pkg;
    // Agent phases: waiting, contending on the lines, reporting a result
    typedef enum logic [1:0] {
        AG_IDLE = 2'd0,
        AG_ARB  = 2'd1,
        AG_DONE = 2'd2
    } agent_state_t;
endpackage

// File: rtl/wired_or_lines.sv
// Model of the shared arbitration lines. Every ID line and the start line
// resolve as the OR of all agents' drives.
// Assumes: the drives come from registers, so no combinational loop forms
// through the agents.
module wired_or_lines #(
    parameter int N    = 4,
    parameter int ID_W = 4
) (
    input  logic [N*ID_W-1:0] drv_flat,
    input  logic [N-1:0]      start_drv,
    output logic [ID_W-1:0]   lines,
    output logic              start_line
);
    // OR-reduce all agents' ID drives and start drives
    always_comb begin
        lines      = '0;
        start_line = 1'b0;
        for (int i = 0; i < N; i++) begin
            lines      = lines | drv_flat[i*ID_W +: ID_W];
            start_line = start_line | start_drv[i];
        end
    end
endmodule

// File: rtl/dist_arb_agent.sv
// One device's arbitration agent. It joins a contest when req is high and
// no contest runs. In every contest cycle it re-drives its ID, masked below
// the highest bit where the lines show 1 and its own ID has 0. After SETTLE
// cycles it reports a win if the lines equal its ID, and a loss otherwise.
// Assumes: IDs are unique and SETTLE >= ID_W, so the lines have settled.
module dist_arb_agent
    import dist_arb_pkg::*;
#(
    parameter int ID_W   = 4,
    parameter int SETTLE = 5,
    parameter int CNT_W  = $clog2(SETTLE + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic [ID_W-1:0] my_id,
    input  logic [ID_W-1:0] lines,
    input  logic            start_seen,
    output logic [ID_W-1:0] drive,
    output logic            start_drv,
    output logic            win,
    output logic            lose
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE - 1);

    agent_state_t     state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [ID_W-1:0]  drive_q;
    logic             result_q;
    logic [ID_W-1:0]  keep;

    // Mask of own bits still allowed: clear below any lost higher bit
    always_comb begin
        logic blocked;
        blocked = 1'b0;
        for (int i = ID_W - 1; i >= 0; i--) begin
            keep[i] = !blocked;
            blocked = blocked | (lines[i] & ~my_id[i]);
        end
    end

    // Phase sequencing, settle counting, drive update and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= AG_IDLE;
            cnt_q    <= '0;
            drive_q  <= '0;
            result_q <= 1'b0;
        end else begin
            case (state_q)
                AG_IDLE: begin
                    if (req && !start_seen) begin
                        state_q <= AG_ARB;
                        cnt_q   <= '0;
                        drive_q <= my_id;
                    end
                end
                AG_ARB: begin
                    cnt_q   <= cnt_q + 1'b1;
                    drive_q <= my_id & keep;
                    if (cnt_q == LAST) begin
                        state_q  <= AG_DONE;
                        result_q <= (lines == my_id);
                        drive_q  <= '0;
                    end
                end
                default: begin
                    state_q <= AG_IDLE;
                end
            endcase
        end
    end

    assign drive     = drive_q;
    assign start_drv = (state_q == AG_ARB);
    assign win       = (state_q == AG_DONE) &&  result_q;
    assign lose      = (state_q == AG_DONE) && !result_q;
endmodule

// File: rtl/dist_arb_cluster.sv
// Top level: N distributed agents sharing one set of OR-resolved ID lines
// and one start line. No central decision is made here. The top only
// wires the agents to the line model and gathers their results.
// Assumes: the IDs on id_flat are unique and held steady.
module dist_arb_cluster #(
    parameter int N      = 4,
    parameter int ID_W   = 4,
    parameter int SETTLE = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      req,
    input  logic [N*ID_W-1:0] id_flat,
    output logic [N-1:0]      grant,
    output logic [N-1:0]      lost,
    output logic              done,
    output logic [ID_W-1:0]   bus_lines,
    output logic              start_line
);
    logic [N*ID_W-1:0] drv_flat;
    logic [N-1:0]      start_drv;

    wired_or_lines #(.N(N), .ID_W(ID_W)) u_lines (
        .drv_flat   (drv_flat),
        .start_drv  (start_drv),
        .lines      (bus_lines),
        .start_line (start_line)
    );

    for (genvar g = 0; g < N; g++) begin : g_agent
        dist_arb_agent #(.ID_W(ID_W), .SETTLE(SETTLE)) u_agent (
            .clk        (clk),
            .rst_n      (rst_n),
            .req        (req[g]),
            .my_id      (id_flat[g*ID_W +: ID_W]),
            .lines      (bus_lines),
            .start_seen (start_line),
            .drive      (drv_flat[g*ID_W +: ID_W]),
            .start_drv  (start_drv[g]),
            .win        (grant[g]),
            .lose       (lost[g])
        );
    end

    // A result cycle is any cycle in which some agent reports
    assign done = |(grant | lost);
endmodule

// File: rtl/dist_arb_checker.sv
// Temporal checks on the cluster ports, attached by bind.
module dist_arb_checker #(
    parameter int N      = 4,
    parameter int ID_W   = 4,
    parameter int SETTLE = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N-1:0]    grant,
    input logic [N-1:0]    lost,
    input logic            done,
    input logic [ID_W-1:0] bus_lines,
    input logic            start_line
);
    localparam int RW = $clog2(SETTLE + 2) + 1;
    logic [RW-1:0] run_len;

    // Length of the current or just-ended run of start_line cycles
    always_ff @(posedge clk) begin
        if (!rst_n) run_len <= '0;
        else        run_len <= start_line ? run_len + 1'b1 : '0;
    end

    p_one_winner_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    p_win_xor_lose_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & lost) == '0);
    p_done_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_after_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_len == RW'(SETTLE)));
    p_lines_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !start_line |-> (bus_lines == '0));
    p_winner_each_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones(grant) == 1));
endmodule

bind dist_arb_cluster dist_arb_checker #(.N(N), .ID_W(ID_W), .SETTLE(SETTLE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .grant      (grant),
    .lost       (lost),
    .done       (done),
    .bus_lines  (bus_lines),
    .start_line (start_line)
);

// File: tb/dist_arb_cluster_bench.sv
// Scoreboard bench: a driver task queues the expected grant and lost
// vectors, and a monitor compares them when done fires.
module dist_arb_cluster_bench;
    localparam int N      = 4;
    localparam int ID_W   = 4;
    localparam int SETTLE = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      req = '0;
    logic [N*ID_W-1:0] id_flat;
    logic [N-1:0]      grant, lost;
    logic              done, start_line;
    logic [ID_W-1:0]   bus_lines;

    int n_chk = 0;
    int n_fail = 0;
    logic [2*N-1:0] exp_q[$];

    always #10 clk = ~clk;

    // Agent IDs: a0=5 (0101), a1=6 (0110), a2=9 (1001), a3=3 (0011)
    assign id_flat = {4'd3, 4'd9, 4'd6, 4'd5};

    dist_arb_cluster #(.N(N), .ID_W(ID_W), .SETTLE(SETTLE)) u_dist_arb_cluster (
        .clk(clk), .rst_n(rst_n), .req(req), .id_flat(id_flat),
        .grant(grant), .lost(lost), .done(done),
        .bus_lines(bus_lines), .start_line(start_line)
    );

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare each reported result against the queued expectation
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected result", {24'd0, grant, lost}, 32'd0);
            end else begin
                logic [2*N-1:0] e;
                e = exp_q.pop_front();
                check(grant == e[2*N-1:N], "R3 grant", grant, e[2*N-1:N]);
                check(lost == e[N-1:0], "R4/R6 lost", lost, e[N-1:0]);
            end
        end
    end

    // Driver: run one contest and check the lines and the timing of the result
    task automatic contest(input logic [N-1:0] mask, input logic [N-1:0] late,
                           input logic [ID_W-1:0] exp_lines,
                           input logic [N-1:0] g, input logic [N-1:0] l);
        @(negedge clk);
        req = mask;
        exp_q.push_back({g, l});
        @(negedge clk);
        check(bus_lines == exp_lines, "R2 lines OR", bus_lines, exp_lines);
        check(start_line == 1'b1, "R2 start", start_line, 1);
        req = late;
        @(negedge clk);
        req = '0;
        repeat (SETTLE - 2) @(negedge clk);
        check(done == 1'b0, "R5 not early", done, 0);
        @(negedge clk);
        check(done == 1'b1, "R5 on time", done, 1);
        check(bus_lines == '0 && start_line == 1'b0, "R5 released",
              {bus_lines, start_line}, 0);
        @(negedge clk);
        check(done == 1'b0, "R5 one cycle", done, 0);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        req = '1;
        repeat (3) @(negedge clk);
        check({grant, lost, done, start_line, bus_lines} == '0, "R1 in reset",
              {grant, lost, done, start_line, bus_lines}, 0);
        req = '0;
        rst_n = 1'b1;
        @(negedge clk);
        check({grant, lost, done, start_line, bus_lines} == '0, "R1 after reset",
              {grant, lost, done, start_line, bus_lines}, 0);
        // R6: no requests, nothing on the lines and no result
        repeat (SETTLE + 2) @(negedge clk);
        check(done == 1'b0 && bus_lines == '0, "R6 idle", {done, bus_lines}, 0);
        // R3/R4: 5 vs 6 -> lines 0111, a1 wins
        contest(4'b0011, 4'b0000, 4'b0111, 4'b0010, 4'b0001);
        // 5 vs 3 -> a0 wins; a1 and a2 are idle (R6)
        contest(4'b1001, 4'b0000, 4'b0111, 4'b0001, 4'b1000);
        // R8: 5, 9, 3 -> 9 drops bits then restores them and wins
        contest(4'b1101, 4'b0000, 4'b1111, 4'b0100, 4'b1001);
        // lone contender wins
        contest(4'b1000, 4'b0000, 4'b0011, 4'b1000, 4'b0000);
        // all four contend
        contest(4'b1111, 4'b0000, 4'b1111, 4'b0100, 4'b1011);
        // R7: a2 requests mid-contest and is ignored
        contest(4'b0011, 4'b0100, 4'b0111, 4'b0010, 4'b0001);
        repeat (SETTLE + 2) @(negedge clk);
        check(done == 1'b0 && start_line == 1'b0, "R7 late request dropped",
              {done, start_line}, 0);
        check(exp_q.size() == 0, "R5 all results seen", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule